// File: doc/BRIEF.md
# Dual-Clock Dual-Mode FIFO Controller

This block is a 9-bit-wide first-in first-out queue whose producer and consumer run on unrelated clocks. Words enter on the write clock and leave on the read clock. The write and read pointers cross between the two clock domains as Gray code, each through a two-stage synchroniser. The storage is an internal register array. Its depth is a power of two set by a parameter, and it is written so that it can map onto block RAM.

Two read protocols are offered, and the choice is made while the master reset is held. In standard mode the consumer asks for each word with the read enable, and the two status pins report full and empty. In fall-through mode the oldest word is placed on the output without being asked for, and the status pins report write-ready and output-valid instead. The queue also reports half-full, almost-full and almost-empty. The almost thresholds use offsets that software loads through a small parallel port on the write clock.

There are two resets. The master reset returns everything to its defaults. The partial reset only empties the queue and keeps the loaded offsets and the chosen mode.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `mrst_n` is low and after it is released with `fwft_sel` low, the outputs read as follows: `rd_stat`=1 (empty), `wr_stat`=0, `almost_empty`=1, `almost_full`=0, `half_full`=0 and `rd_data`=0.
- R2: The mode is the level of `fwft_sel` on the last write-clock and read-clock edges of a master reset (1 = fall-through, 0 = standard). In standard mode `wr_stat` is the full flag and `rd_stat` is the empty flag. In fall-through mode `wr_stat` is write-ready (not full) and `rd_stat` is output-valid.
- R3: In standard mode, a read-clock edge that sees `rd_en` high while the queue is not empty places the oldest word on `rd_data` at that edge. Words come out in the order they were written.
- R4: Latency from a write into an empty queue, counting read-clock edges from the first edge after the write edge. In standard mode `rd_stat` falls on the third edge. In fall-through mode the word appears with `rd_stat` high on the fourth edge with no read enable, and it stays on the output until an edge that sees `rd_en`.
- R5: A write while the storage is full is ignored: the word is dropped and the stored words are unchanged.
- R6: A read while the queue is empty (standard) or while `rd_stat` is low (fall-through) is ignored, and `rd_data` keeps its value.
- R7: The storage holds 2^AW words, and the full condition shows on the write-clock edge that stores the last of them. In fall-through mode the output register holds one more word, so write-ready falls on the write of word 2^AW+1.
- R8: `half_full` is high when the storage holds more than 2^(AW-1) words. It is updated on the write-clock edge of each write.
- R9: `almost_full` is high when the free storage (2^AW minus the stored words) is at or below the full offset.
- R10: `almost_empty` is high when the fill level is at or below the empty offset. The fill level is the stored words, plus one in fall-through mode while `rd_stat` is high.
- R11: On a write-clock edge where `cfg_load` is high and the storage is empty, `cfg_val` is loaded into the full offset (`cfg_sel`=1) or the empty offset (`cfg_sel`=0). When the storage is not empty, the load is ignored.
- R12: A low `prst_n` empties the queue but keeps both offsets and the mode.
- R13: A master reset sets the full offset to AF_DEF and the empty offset to AE_DEF (both 2 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| prst_n | input | 1 | Partial reset, active low, empties the queue only |
| fwft_sel | input | 1 | Mode chosen during master reset: 1 fall-through, 0 standard |
| wr_en | input | 1 | Write request |
| wr_data | input | DW (9) | Word to store |
| cfg_load | input | 1 | Offset load strobe (write clock) |
| cfg_sel | input | 1 | 1 selects the full offset, 0 the empty offset |
| cfg_val | input | AW+1 (5) | Offset value |
| wr_stat | output | 1 | Full (standard) or write-ready (fall-through) |
| almost_full | output | 1 | Free space at or below the full offset |
| half_full | output | 1 | More than half of the storage in use |
| rd_en | input | 1 | Read request |
| rd_data | output | DW (9) | Output word |
| rd_stat | output | 1 | Empty (standard) or output-valid (fall-through) |
| almost_empty | output | 1 | Fill level at or below the empty offset |

## Verification
The flags on the write side (full, write-ready, half-full, almost-full) change on the write-clock edge that performs the write, so the bench samples them at the next falling edge of the write clock. A new word reaches the read side only after the two-stage synchroniser and the registered empty flag. The bench therefore counts read-clock edges from the write edge and checks that standard-mode empty falls on the third edge and that a fall-through word becomes valid on the fourth. Read data is sampled at the falling edge after the rising edge that fetched it. Checks that depend on the pointer seen from the other domain first wait several cycles, so that both synchronisers have settled.

// File: rtl/dmf_pkg.sv
`timescale 1ns/1ps
package dmf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dmf_gray_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser for a Gray-coded pointer, followed by a Gray-to-binary decode.
module dmf_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (clr) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_dec
    assign bin_out[i] = ^s2[W-1:i];
  end
endmodule

// File: rtl/dmf_mem.sv
`timescale 1ns/1ps
// Simple dual-port storage: write on wr_clk, registered read on rd_clk.
module dmf_mem #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          rd_clr,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_clr)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dmf_wr_side.sv
`timescale 1ns/1ps
// Write domain: pointer, full / half / almost-full flags, offset registers.
module dmf_wr_side
  import dmf_pkg::*;
#(
  parameter int AW     = 4,
  parameter int AF_DEF = 2,
  parameter int AE_DEF = 2,
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic          cfg_load,
  input  logic          cfg_sel,
  input  logic [CW-1:0] cfg_val,
  input  logic [CW-1:0] rbin_s,
  output logic [CW-1:0] wbin,
  output logic [CW-1:0] wgray,
  output logic          we,
  output logic          full,
  output logic          wr_stat,
  output logic          almost_full,
  output logic          half_full,
  output logic [CW-1:0] ae_ofs
);
  localparam logic [CW-1:0] DEPTH_C = CW'(1 << AW);
  localparam logic [CW-1:0] HALF_C  = CW'(1 << (AW - 1));

  rd_mode_e      mode;
  logic [CW-1:0] af_ofs;
  logic          full_r, af_r, hf_r;
  logic [CW-1:0] wbin_nxt, cnt_nxt;
  logic          store_empty;

  assign we          = wr_en & ~full_r;
  assign wbin_nxt    = wbin + CW'(we);
  assign cnt_nxt     = wbin_nxt - rbin_s;
  assign store_empty = (wbin == rbin_s);

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      mode   <= rd_mode_e'(fwft_sel);
      af_ofs <= CW'(AF_DEF);
      ae_ofs <= CW'(AE_DEF);
      wbin   <= '0;
      wgray  <= '0;
      full_r <= 1'b0;
      af_r   <= 1'b0;
      hf_r   <= 1'b0;
    end else if (!prst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      full_r <= 1'b0;
      af_r   <= 1'b0;
      hf_r   <= 1'b0;
    end else begin
      wbin   <= wbin_nxt;
      wgray  <= wbin_nxt ^ (wbin_nxt >> 1);
      full_r <= (cnt_nxt == DEPTH_C);
      af_r   <= ((DEPTH_C - cnt_nxt) <= af_ofs);
      hf_r   <= (cnt_nxt > HALF_C);
      if (cfg_load && store_empty) begin
        if (cfg_sel) af_ofs <= cfg_val;
        else         ae_ofs <= cfg_val;
      end
    end
  end

  assign full        = full_r;
  assign wr_stat     = (mode == MODE_FWFT) ? ~full_r : full_r;
  assign almost_full = af_r;
  assign half_full   = hf_r;
endmodule

// File: rtl/dmf_rd_side.sv
`timescale 1ns/1ps
// Read domain: pointer, mode-dependent fetch, empty / valid and almost-empty flags.
module dmf_rd_side
  import dmf_pkg::*;
#(
  parameter int AW = 4,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic          rd_en,
  input  logic [CW-1:0] wbin_s,
  input  logic [CW-1:0] ae_ofs_w,
  output logic [CW-1:0] rbin,
  output logic [CW-1:0] rgray,
  output logic          fetch,
  output logic          rd_stat,
  output logic          almost_empty,
  output logic          fwft
);
  rd_mode_e      mode;
  logic          empty_r, valid_r, ae_r;
  logic [CW-1:0] ae_s1, ae_s2;
  logic [CW-1:0] rbin_nxt;
  logic          valid_nxt;
  logic [CW:0]   lvl_nxt;

  assign fwft      = (mode == MODE_FWFT);
  assign fetch     = fwft ? (~empty_r & (~valid_r | rd_en)) : (rd_en & ~empty_r);
  assign rbin_nxt  = rbin + CW'(fetch);
  assign valid_nxt = fwft & (fetch | (valid_r & ~rd_en));
  assign lvl_nxt   = {1'b0, wbin_s - rbin_nxt} + (CW+1)'(valid_nxt);

  // The offset only changes while the storage is empty, so two stages are enough.
  always_ff @(posedge clk) begin
    ae_s1 <= ae_ofs_w;
    ae_s2 <= ae_s1;
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      mode    <= rd_mode_e'(fwft_sel);
      rbin    <= '0;
      rgray   <= '0;
      empty_r <= 1'b1;
      valid_r <= 1'b0;
      ae_r    <= 1'b1;
    end else if (!prst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_r <= 1'b1;
      valid_r <= 1'b0;
      ae_r    <= 1'b1;
    end else begin
      rbin    <= rbin_nxt;
      rgray   <= rbin_nxt ^ (rbin_nxt >> 1);
      empty_r <= (rbin_nxt == wbin_s);
      valid_r <= valid_nxt;
      ae_r    <= (lvl_nxt <= {1'b0, ae_s2});
    end
  end

  assign rd_stat      = fwft ? valid_r : empty_r;
  assign almost_empty = ae_r;
endmodule

// File: rtl/dual_mode_fifo.sv
`timescale 1ns/1ps
module dual_mode_fifo #(
  parameter int DW     = 9,
  parameter int AW     = 4,
  parameter int AF_DEF = 2,
  parameter int AE_DEF = 2,
  localparam int CW    = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          cfg_load,
  input  logic          cfg_sel,
  input  logic [CW-1:0] cfg_val,
  output logic          wr_stat,
  output logic          almost_full,
  output logic          half_full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_stat,
  output logic          almost_empty
);
  logic [CW-1:0] wbin, wgray, rbin, rgray, wbin_s, rbin_s, ae_ofs;
  logic          we, full_w, fetch, rd_fwft;
  logic          clr_any;

  assign clr_any = ~mrst_n | ~prst_n;

  dmf_wr_side #(.AW(AW), .AF_DEF(AF_DEF), .AE_DEF(AE_DEF)) u_wr (
    .clk(wr_clk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .cfg_load(cfg_load), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .rbin_s(rbin_s), .wbin(wbin), .wgray(wgray), .we(we), .full(full_w),
    .wr_stat(wr_stat), .almost_full(almost_full), .half_full(half_full),
    .ae_ofs(ae_ofs)
  );

  dmf_rd_side #(.AW(AW)) u_rd (
    .clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
    .rd_en(rd_en), .wbin_s(wbin_s), .ae_ofs_w(ae_ofs), .rbin(rbin),
    .rgray(rgray), .fetch(fetch), .rd_stat(rd_stat),
    .almost_empty(almost_empty), .fwft(rd_fwft)
  );

  dmf_gray_sync #(.W(CW)) u_rsync (
    .clk(wr_clk), .clr(clr_any), .gray_in(rgray), .bin_out(rbin_s)
  );

  dmf_gray_sync #(.W(CW)) u_wsync (
    .clk(rd_clk), .clr(clr_any), .gray_in(wgray), .bin_out(wbin_s)
  );

  dmf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wr_clk(wr_clk), .we(we), .waddr(wbin[AW-1:0]), .wdata(wr_data),
    .rd_clk(rd_clk), .rd_clr(~mrst_n), .re(fetch), .raddr(rbin[AW-1:0]),
    .rdata(rd_data)
  );
endmodule

// File: rtl/dual_mode_fifo_chk.sv
`timescale 1ns/1ps
module dual_mode_fifo_chk #(
  parameter int DW = 9,
  parameter int CW = 5
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          mrst_n,
  input logic          prst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          rd_stat,
  input logic          half_full,
  input logic          almost_full,
  input logic [CW-1:0] wbin,
  input logic [CW-1:0] wgray,
  input logic [CW-1:0] rbin,
  input logic          full_w,
  input logic          rd_fwft
);
  // R5: a write into full storage leaves the write pointer where it was
  a_r5_no_overflow: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
    (full_w && wr_en) |=> $stable(wbin));

  // R6: a standard-mode read while empty moves neither pointer nor data
  a_r6_no_underflow: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
    (!rd_fwft && rd_stat && rd_en) |=> ($stable(rbin) && $stable(rd_data)));

  // R4: a fall-through word stays put until it is consumed
  a_r4_fwft_hold: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
    (rd_fwft && rd_stat && !rd_en) |=> (rd_stat && $stable(rd_data)));

  // R4: the write pointer that crosses domains changes at most one bit per edge
  a_r4_gray_step: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R7: full storage is always also past half and inside the full margin
  a_r7_full_flags: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
    full_w |-> (half_full && almost_full));
endmodule

bind dual_mode_fifo dual_mode_fifo_chk #(.DW(DW), .CW(CW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
  .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .rd_stat(rd_stat),
  .half_full(half_full), .almost_full(almost_full), .wbin(wbin),
  .wgray(wgray), .rbin(rbin), .full_w(full_w), .rd_fwft(rd_fwft)
);

// File: tb/tb_dual_mode_fifo.sv
`timescale 1ns/1ps
module tb_dual_mode_fifo;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int CW = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic wr_clk, rd_clk, mrst_n, prst_n, fwft_sel;
  logic wr_en, cfg_load, cfg_sel, rd_en;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] cfg_val;
  logic wr_stat, almost_full, half_full, rd_stat, almost_empty;
  logic [DW-1:0] rd_data;

  int vectors = 0;
  int miscompares = 0;

  // Stimulus word in the upper half, expected output word in the lower half
  localparam logic [17:0] VEC [12] = '{
    {9'h000, 9'h000}, {9'h1FF, 9'h1FF}, {9'h155, 9'h155}, {9'h0AA, 9'h0AA},
    {9'h101, 9'h101}, {9'h080, 9'h080}, {9'h0F0, 9'h0F0}, {9'h10F, 9'h10F},
    {9'h033, 9'h033}, {9'h1CC, 9'h1CC}, {9'h001, 9'h001}, {9'h100, 9'h100}
  };

  dual_mode_fifo #(.DW(DW), .AW(AW)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_load(cfg_load), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .wr_stat(wr_stat), .almost_full(almost_full), .half_full(half_full),
    .rd_en(rd_en), .rd_data(rd_data), .rd_stat(rd_stat),
    .almost_empty(almost_empty)
  );

  initial begin
    wr_clk = 0;
    forever #10 wr_clk = ~wr_clk;
  end
  initial begin
    rd_clk = 0;
    #5;
    forever #10 rd_clk = ~rd_clk;
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
    @(negedge rd_clk);
  endtask

  task automatic do_reset(input logic master, input logic mode);
    @(negedge wr_clk);
    fwft_sel = mode;
    if (master) mrst_n = 1'b0;
    else        prst_n = 1'b0;
    repeat (5) @(negedge wr_clk);
    mrst_n = 1'b1;
    prst_n = 1'b1;
    settle();
  endtask

  task automatic load_ofs(input logic sel, input logic [CW-1:0] val);
    @(negedge wr_clk);
    cfg_load = 1'b1;
    cfg_sel = sel;
    cfg_val = val;
    @(negedge wr_clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    #4_000_000;
    miscompares++;
    $display("FAIL watchdog: actual %h expected %h", 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    mrst_n = 0; prst_n = 1; fwft_sel = 0;
    wr_en = 0; wr_data = '0; cfg_load = 0; cfg_sel = 0; cfg_val = '0; rd_en = 0;
    repeat (5) @(negedge wr_clk);
    mrst_n = 1;
    settle();

    // R1 reset state, standard mode
    check("R1 empty", rd_stat, 1);
    check("R1 wr_stat", wr_stat, 0);
    check("R1 almost_empty", almost_empty, 1);
    check("R1 almost_full", almost_full, 0);
    check("R1 half_full", half_full, 0);
    check("R1 rd_data", rd_data, 0);

    // Vector table: R3 order and data, R8 half-full past the midpoint
    foreach (VEC[i]) push(VEC[i][17:9]);
    settle();
    check("R8 half_full 12 stored", half_full, 1);
    check("R10 almost_empty 12 stored", almost_empty, 0);
    foreach (VEC[i]) begin
      pop();
      check("R3 data order", rd_data, VEC[i][8:0]);
    end
    settle();
    check("R2 std empty after drain", rd_stat, 1);
    pop();
    check("R6 read while empty keeps data", rd_data, 9'h100);

    // R4 standard-mode latency: empty falls on the third read edge
    @(negedge wr_clk);
    wr_en = 1; wr_data = 9'h05A;
    @(posedge wr_clk);
    #2 wr_en = 0;
    repeat (2) @(posedge rd_clk);
    #1 check("R4 std still empty at edge 2", rd_stat, 1);
    @(posedge rd_clk);
    #1 check("R4 std not empty at edge 3", rd_stat, 0);
    pop();
    check("R3 latency word", rd_data, 9'h05A);
    settle();

    // R7/R8/R9 fill to full, R5 overflow dropped
    for (int i = 1; i <= DEPTH; i++) begin
      push(DW'(9'h040 + i));
      if (i == 8)  check("R8 half_full at 8", half_full, 0);
      if (i == 9)  check("R8 half_full at 9", half_full, 1);
      if (i == 13) check("R9 almost_full free 3", almost_full, 0);
      if (i == 14) check("R9 almost_full free 2", almost_full, 1);
      if (i == 15) check("R7 not full at 15", wr_stat, 0);
    end
    check("R7 full at 16", wr_stat, 1);
    push(9'h1EE);
    settle();
    for (int i = 1; i <= DEPTH; i++) begin
      pop();
      check("R5 stored word intact", rd_data, DW'(9'h040 + i));
    end
    settle();
    check("R5 overflow word dropped", rd_stat, 1);

    // R11 offset loading while empty, then an ignored load
    load_ofs(1'b0, CW'(5));
    load_ofs(1'b1, CW'(6));
    for (int i = 1; i <= 5; i++) push(DW'(9'h0C0 + i));
    settle();
    check("R11 empty offset 5 at level 5", almost_empty, 1);
    push(9'h0C6);
    settle();
    check("R10 almost_empty level 6", almost_empty, 0);
    check("R11 full offset 6 at free 10", almost_full, 0);
    load_ofs(1'b1, CW'(15));
    settle();
    check("R11 load while not empty ignored", almost_full, 0);
    for (int i = 7; i <= 9; i++) push(DW'(9'h0C0 + i));
    check("R9 free 7 offset 6", almost_full, 0);
    push(9'h0CA);
    check("R9 free 6 offset 6", almost_full, 1);

    // R12 partial reset keeps offsets and mode
    do_reset(1'b0, 1'b1);
    check("R12 queue empty and standard mode kept", rd_stat, 1);
    check("R12 half_full cleared", half_full, 0);
    check("R12 almost_full cleared", almost_full, 0);
    for (int i = 1; i <= 5; i++) push(DW'(9'h0D0 + i));
    settle();
    check("R12 empty offset kept", almost_empty, 1);
    for (int i = 6; i <= 10; i++) push(DW'(9'h0D0 + i));
    check("R12 full offset kept", almost_full, 1);
    pop();
    check("R12 first word after partial reset", rd_data, 9'h0D1);

    // R13/R2 master reset into fall-through mode
    do_reset(1'b1, 1'b1);
    check("R2 fwft write-ready", wr_stat, 1);
    check("R2 fwft not valid", rd_stat, 0);
    check("R13 almost_empty", almost_empty, 1);
    check("R13 almost_full", almost_full, 0);
    check("R13 rd_data cleared", rd_data, 0);

    // R4 fall-through latency: valid on the fourth read edge, no rd_en
    @(negedge wr_clk);
    wr_en = 1; wr_data = 9'h0A1;
    @(posedge wr_clk);
    #2 wr_en = 0;
    repeat (3) @(posedge rd_clk);
    #1 check("R4 fwft not yet valid at edge 3", rd_stat, 0);
    @(posedge rd_clk);
    #1 check("R4 fwft valid at edge 4", rd_stat, 1);
    check("R4 fwft first word", rd_data, 9'h0A1);

    push(9'h0A2);
    settle();
    check("R13 default empty offset level 2", almost_empty, 1);
    push(9'h0A3);
    settle();
    check("R13 default empty offset level 3", almost_empty, 0);
    check("R4 fwft word held without rd_en", rd_data, 9'h0A1);
    for (int i = 4; i <= DEPTH; i++) push(DW'(9'h0A0 + i));
    check("R7 fwft ready with 16 words", wr_stat, 1);
    push(DW'(9'h0A0 + DEPTH + 1));
    check("R7 fwft not ready with 17 words", wr_stat, 0);
    settle();
    for (int i = 1; i <= DEPTH + 1; i++) begin
      @(negedge rd_clk);
      check("R4 fwft valid while draining", rd_stat, 1);
      check("R4 fwft data order", rd_data, DW'(9'h0A0 + i));
      rd_en = 1;
      @(negedge rd_clk);
      rd_en = 0;
    end
    settle();
    check("R6 fwft not valid after drain", rd_stat, 0);
    pop();
    check("R6 fwft read while not valid keeps data", rd_data, DW'(9'h0A0 + DEPTH + 1));
    check("R6 fwft still not valid", rd_stat, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule